// File: doc/BRIEF.md
# DMA Bridge Interrupt Aggregator

This block gathers the completion and error events of a DMA bridge that serves one USB channel and a number of audio channels. Each audio channel has a playback and a record direction. Every event has a sticky status flag and an enable flag. All of the flags sit in one 32-bit control/status word, which software reaches through a simple read/write port. Status flags are cleared by writing zero to them. Writing one to a status flag leaves it as it is, so software can write back the word it read with only the enables changed, without losing or forging an event.

Pending events are status flags whose enable is set. They are grouped by kind onto three registered, active-high interrupt lines: address error, transfer end and half transfer. A masked event keeps its status flag, but it raises no line. Software reads the word to find out which event caused an interrupt.

Event numbering runs as follows. Event 0 is USB transfer done and event 1 is USB address error. From event 2 on, each audio channel takes four events in turn: playback all done, playback half done, record all done, record half done. The parameter `AUDIO_CH` sets the number of audio channels, and the register layout has room for at most two.

Top module: `dmabrg_irq_agg`

## Requirements
- R1: After reset every bit of the control/status word reads 0 and all three interrupt lines are low.
- R2: A one-cycle pulse on `evt[i]` sets status flag i at the next clock edge. The flag stays set until it is cleared. The status flag of event 0 is bit 0, that of event 1 is bit 1, and that of audio event n (n ≥ 2) is bit n+14.
- R3: A write with 0 in a status bit position clears that flag. A write with 1 there leaves the flag unchanged and never sets a clear flag.
- R4: When an event pulse and a write that clears the same flag arrive in the same cycle, the flag ends up set.
- R5: A write loads every enable flag from its bit position: bit 8 for event 0, bit 9 for event 1, and bit n+22 for audio event n. A read returns the enables in the same positions.
- R6: Bits 15..10 and 7..2 read as 0 and ignore writes. Bits of audio events beyond `AUDIO_CH` do the same.
- R7: `irq_addr_err` is high in the cycle after event 1 is both set and enabled, and low otherwise.
- R8: `irq_xfer_end` is high in the cycle after any of events 0, 2, 4, 6 or 8 is both set and enabled.
- R9: `irq_half` is high in the cycle after any of events 3, 5, 7 or 9 is both set and enabled.
- R10: A status flag whose enable is 0 still sets and reads as 1, but it drives no interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt | input | 2+4*AUDIO_CH | One-cycle event pulses, one bit per event |
| reg_wr | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control/status word |
| irq_addr_err | output | 1 | Address-error interrupt line |
| irq_xfer_end | output | 1 | Transfer-end interrupt line |
| irq_half | output | 1 | Half-transfer interrupt line |

## Verification
The bench builds the block with `AUDIO_CH` = 2. With that value all ten events exist, every bit of both 8-bit audio fields is live, and each of the three lines has its full set of sources. A reference model in the bench checks the word and the three lines on every clock. The stimulus covers events fired one at a time, writes of only ones, clears that collide with events, masked events, and a long pseudo-random stretch in which writes and events overlap freely.

// File: rtl/dmabrg_irq_agg.sv
module dmabrg_irq_agg #(
  parameter int AUDIO_CH = 2,
  localparam int EV_N = 2 + 4 * AUDIO_CH,
  localparam int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] evt,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_addr_err,
  output logic            irq_xfer_end,
  output logic            irq_half
);

  function automatic int sts_pos(int i);
    return (i < 2) ? i : i + 14;
  endfunction

  function automatic int en_pos(int i);
    return (i < 2) ? i + 8 : i + 22;
  endfunction

  function automatic logic [EV_N-1:0] kind_mask(int kind);
    logic [EV_N-1:0] m;
    m = '0;
    for (int i = 0; i < EV_N; i++) begin
      if (kind == 0) m[i] = (i == 1);
      else if (kind == 1) m[i] = (i == 0) || (i >= 2 && i % 2 == 0);
      else m[i] = (i >= 3 && i % 2 == 1);
    end
    return m;
  endfunction

  function automatic logic [DW-1:0] used_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < EV_N; i++) begin
      m[sts_pos(i)] = 1'b1;
      m[en_pos(i)]  = 1'b1;
    end
    return m;
  endfunction

  localparam logic [EV_N-1:0] ERR_M  = kind_mask(0);
  localparam logic [EV_N-1:0] END_M  = kind_mask(1);
  localparam logic [EV_N-1:0] HALF_M = kind_mask(2);
  localparam logic [DW-1:0]   RSV_M  = ~used_mask();

  logic [EV_N-1:0] sts, en, wr_sts, wr_en, pend;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < EV_N; i++) begin
      wr_sts[i] = reg_wdata[sts_pos(i)];
      wr_en[i]  = reg_wdata[en_pos(i)];
      reg_rdata[sts_pos(i)] = sts[i];
      reg_rdata[en_pos(i)]  = en[i];
    end
  end

  assign pend = sts & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (reg_wr ? (sts & wr_sts) : sts) | evt;
      if (reg_wr) en <= wr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_addr_err <= 1'b0;
      irq_xfer_end <= 1'b0;
      irq_half     <= 1'b0;
    end else begin
      irq_addr_err <= |(pend & ERR_M);
      irq_xfer_end <= |(pend & END_M);
      irq_half     <= |(pend & HALF_M);
    end
  end

  // R2
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts & $past(evt)) == $past(evt)));

  // R3
  sts_no_forge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0) |=> ((sts & ~$past(sts)) == '0));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & RSV_M) == '0);

  // R7
  addr_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] && reg_rdata[9] |=> irq_addr_err);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !(irq_addr_err || irq_xfer_end || irq_half));

endmodule

// File: tb/sim_dmabrg_irq_agg.sv
module sim_dmabrg_irq_agg;
  logic clk = 0, rst_n = 0;
  logic [9:0] evt = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_addr_err, irq_xfer_end, irq_half;
  int checks = 0, fails = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  dmabrg_irq_agg u0 (.clk, .rst_n, .evt, .reg_wr, .reg_wdata, .reg_rdata,
                     .irq_addr_err, .irq_xfer_end, .irq_half);

  function automatic int sp(int i); return (i < 2) ? i : i + 14; endfunction
  function automatic int ep(int i); return (i < 2) ? i + 8 : i + 22; endfunction

  bit [9:0] ms, me;
  bit [2:0] mi;

  always @(posedge clk or negedge rst_n) begin
    bit [9:0] ns, ne;
    bit [2:0] ni;
    if (!rst_n) begin
      ms <= '0; me <= '0; mi <= '0;
    end else begin
      ni = '0;
      for (int i = 0; i < 10; i++) begin
        ns[i] = ms[i];
        ne[i] = me[i];
        if (reg_wr) begin
          if (!reg_wdata[sp(i)]) ns[i] = 0;
          ne[i] = reg_wdata[ep(i)];
        end
        if (evt[i]) ns[i] = 1;
        if (ms[i] && me[i]) begin
          if (i == 1) ni[0] = 1;
          else if (i % 2 == 0) ni[1] = 1;
          else ni[2] = 1;
        end
      end
      ms <= ns; me <= ne; mi <= ni;
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 10; i++) begin
      w[sp(i)] = ms[i];
      w[ep(i)] = me[i];
    end
    return w;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 R3 R4 R5 R6 word", reg_rdata, model_word());
    chk("R7 addr line", {31'b0, irq_addr_err}, {31'b0, mi[0]});
    chk("R8 end line", {31'b0, irq_xfer_end}, {31'b0, mi[1]});
    chk("R9 half line", {31'b0, irq_half}, {31'b0, mi[2]});
  end

  task automatic step(logic [9:0] e, logic w, logic [31:0] d);
    @(negedge clk);
    evt = e; reg_wr = w; reg_wdata = d;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step('0, 0, '0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_2357;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R1 reset lines", {29'b0, irq_addr_err, irq_xfer_end, irq_half}, 32'h0);
    cmp_on = 1;
    // R5 enable all events, R6 reserved bits written as ones
    step('0, 1, 32'hFF00_FFFF);
    idle(2);
    for (int i = 0; i < 10; i++) begin
      step(10'(1 << i), 0, '0);
      idle(2);
      step('0, 1, 32'hFF00_0300);
      idle(2);
    end
    // R3 write of only ones keeps flags
    step(10'h3FF, 0, '0);
    step('0, 1, 32'hFFFF_FFFF);
    idle(2);
    // R4 clear colliding with event 0
    step(10'h001, 1, 32'hFF00_0300);
    @(negedge clk);
    chk("R4 set wins over clear", {31'b0, reg_rdata[0]}, 32'h1);
    step('0, 1, 32'h0000_0000);
    idle(2);
    // R10 masked event 3 sets status, no line
    step(10'h008, 0, '0);
    idle(2);
    chk("R10 masked status set", {31'b0, reg_rdata[17]}, 32'h1);
    chk("R10 masked no line", {29'b0, irq_addr_err, irq_xfer_end, irq_half}, 32'h0);
    step('0, 1, 32'h0100_0000);
    idle(3);
    // pseudo-random stretch
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step((lfsr[3:0] == 0) ? lfsr[13:4] : 10'(1 << (lfsr[7:4] % 10)) & {10{lfsr[8]}},
           lfsr[11:9] == 0, lfsr ^ {lfsr[15:0], lfsr[31:16]});
    end
    idle(3);
    cmp_on = 0;
    finish_up();
  end
endmodule